// File: doc/BRIEF.md
# Dial Combination Lock Sequencer

This block is a clocked state machine that guards a three-step dial combination. Each dial operation arrives as a turn direction and a dial number, and a single-cycle strobe marks it as valid. The lock opens only when the steps right-13, left-22, right-3 arrive in that order. Entering the right numbers in a different order does not open it, and neither does a turn in the wrong direction.

Progress through the combination is held in two state bits. The state is shown on an observation port. A registered unlock output is high only while the machine is in the open state. Once open, the lock stays open until a relock request or a synchronous reset returns it to the idle state. The dial numbers and directions of the three steps are elaboration-time parameters.

Top module: `lock_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is idle (`state` = 2'b00) and `unlock` = 0. Reset takes priority over every other input.
- R2: The state port uses this encoding: idle 2'b00, first step seen 2'b01, first two steps seen 2'b10, open 2'b11.
- R3: Accepted operations must run right-13, then left-22, then right-3, where `dir` = 1 means right and `dir` = 0 means left. This order moves the state through 01, 10 and 11. The state and `unlock` change one clock edge after each operation is accepted.
- R4: `unlock` is 1 exactly when `state` is 2'b11. It is a Moore output and is registered.
- R5: At an edge where `op_valid` and `relock` are both low, the state holds, whatever `dir` and `value` carry.
- R6: In states 00, 01 or 10, an accepted operation that is not the next expected step sends the state to 00. The one exception is an operation equal to right-13, which sends it to 01.
- R7: The correct number turned in the wrong direction counts as a mismatch. For example, left-13 from idle gives 00 and right-22 from 01 gives 00.
- R8: In the open state, accepted operations of any value leave the state at 11.
- R9: `relock` high at an edge sends the state to 00 from any state. It takes priority over an accepted operation in the same cycle.
- R10: The three correct steps in any other order never reach state 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| dir | input | 1 | Turn direction: 1 = right, 0 = left |
| value | input | VAL_W | Dial number, 0 to 39 |
| relock | input | 1 | Return from any state to idle |
| unlock | output | 1 | High while the lock is open |
| state | output | 2 | Current progress through the combination |

## Verification
A wrong internal state is visible on the `state` port one edge after the operation that caused it. When the wrong state concerns the open condition, `unlock` shows it in the same cycle. A transition that is lost or taken wrongly only matters for the steps that follow, so the sequences chain operations together. These include partial entries followed by right-13, wrong directions in the middle of a sequence, and relock against an operation in the same cycle. With these chains, a bad transition shows as a mismatch on the very next sample.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STEPS = 3;

  typedef enum logic [1:0] {
    LK_IDLE = 2'b00,
    LK_ONE  = 2'b01,
    LK_TWO  = 2'b10,
    LK_OPEN = 2'b11
  } lock_state_e;
endpackage

// File: rtl/lock_step_match.sv
module lock_step_match #(
  parameter int VAL_W = 6,
  parameter int STEPS = 3,
  parameter logic [STEPS-1:0]       SEQ_DIR = '0,
  parameter logic [STEPS*VAL_W-1:0] SEQ_VAL = '0
) (
  input  logic             dir,
  input  logic [VAL_W-1:0] value,
  output logic [STEPS-1:0] hit
);
  // one comparator per combination step
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign hit[i] = (dir == SEQ_DIR[i]) && (value == SEQ_VAL[i*VAL_W +: VAL_W]);
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e      cur,
  input  logic             op_valid,
  input  logic             relock,
  input  logic [STEPS-1:0] hit,
  output lock_state_e      nxt
);
  always_comb begin
    nxt = cur;
    if (relock) begin
      nxt = LK_IDLE;
    end else if (op_valid) begin
      case (cur)
        LK_OPEN: nxt = LK_OPEN;
        LK_TWO:  nxt = hit[2] ? LK_OPEN : (hit[0] ? LK_ONE : LK_IDLE);
        LK_ONE:  nxt = hit[1] ? LK_TWO  : (hit[0] ? LK_ONE : LK_IDLE);
        default: nxt = hit[0] ? LK_ONE  : LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int VAL_W = 6,
  parameter logic [STEPS-1:0]       SEQ_DIR = 3'b101,
  parameter logic [STEPS*VAL_W-1:0] SEQ_VAL = {VAL_W'(3), VAL_W'(22), VAL_W'(13)}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             dir,
  input  logic [VAL_W-1:0] value,
  input  logic             relock,
  output logic             unlock,
  output logic [1:0]       state
);
  lock_state_e      state_q, state_d;
  logic             unlock_q;
  logic [STEPS-1:0] hit;

  lock_step_match #(
    .VAL_W(VAL_W), .STEPS(STEPS), .SEQ_DIR(SEQ_DIR), .SEQ_VAL(SEQ_VAL)
  ) match_i (
    .dir(dir), .value(value), .hit(hit)
  );

  lock_next_state next_i (
    .cur(state_q), .op_valid(op_valid), .relock(relock), .hit(hit), .nxt(state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LK_IDLE;
      unlock_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      unlock_q <= (state_d == LK_OPEN);
    end
  end

  assign state  = state_q;
  assign unlock = unlock_q;

  AST_UNLOCK_MOORE: assert property (@(posedge clk) disable iff (rst)
    unlock == (state_q == LK_OPEN)); // R4
  AST_HOLD_NO_OP: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> $stable(state_q)); // R5
  AST_RELOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    relock |=> (state_q == LK_IDLE)); // R9
  AST_OPEN_PERSIST: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_OPEN && !relock) |=> (state_q == LK_OPEN)); // R8
  AST_OPEN_FROM_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past(state_q) == LK_TWO)); // R3
endmodule

// File: tb/lock_fsm_tb_top.sv
module lock_fsm_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       dir = 1'b0;
  logic [5:0] value = '0;
  logic       relock = 1'b0;
  logic       unlock;
  logic [1:0] state;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [1:0] mdl = 2'b00;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  lock_fsm dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .dir(dir),
    .value(value), .relock(relock), .unlock(unlock), .state(state)
  );

  // reference model built from the requirement list
  function automatic logic [1:0] model(logic [1:0] cur, logic r, logic rel,
                                       logic v, logic d, logic [5:0] n);
    if (r || rel) return 2'b00;
    if (!v) return cur;
    if (cur == 2'b11) return 2'b11;
    if (cur == 2'b10 && d && n == 6'd3) return 2'b11;
    if (cur == 2'b01 && !d && n == 6'd22) return 2'b10;
    if (d && n == 6'd13) return 2'b01;
    return 2'b00;
  endfunction

  task automatic step(input logic r, input logic rel, input logic v,
                      input logic d, input logic [5:0] n, input string tag);
    @(negedge clk);
    rst = r; relock = rel; op_valid = v; dir = d; value = n;
    mdl = model(mdl, r, rel, v, d, n);
    @(posedge clk);
    #1;
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
    rst = 0; relock = 0; op_valid = 0;
  endtask

  task automatic op(input logic d, input logic [5:0] n, input string tag);
    step(0, 0, 1, d, n, tag);
  endtask

  task automatic open_it(input string tag);
    op(1, 13, tag); op(0, 22, tag); op(1, 3, tag);
  endtask

  // monitor: compare each expected item one half-cycle after the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (state !== e) begin
        n_fail++;
        $display("FAIL %s state: actual %b expected %b", t, state, e);
      end
      n_run++;
      if (unlock !== (e == 2'b11)) begin
        n_fail++;
        $display("FAIL R4 (%s) unlock: actual %b expected %b", t, unlock, (e == 2'b11));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (state !== 2'b00 || unlock !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: actual %b/%b expected 00/0", state, unlock);
    end
    rst = 0;

    open_it("R3 R2 correct sequence");
    op(1, 13, "R8 open ignores R13");
    op(0, 5, "R8 open ignores L5");
    step(0, 0, 0, 1, 3, "R8 idle cycle while open");
    step(0, 1, 0, 0, 0, "R9 relock from open");

    step(0, 0, 0, 1, 13, "R5 no strobe with R13 on bus");
    op(1, 13, "R6 R13 from idle");
    step(0, 0, 0, 0, 22, "R5 no strobe with L22 on bus");
    op(1, 22, "R7 wrong direction R22");
    op(0, 13, "R7 wrong direction L13");

    op(1, 3, "R10 out of order R3");
    op(0, 22, "R10 out of order L22");
    op(1, 13, "R10 out of order R13");
    op(1, 3, "R10 R3 too early");
    op(0, 22, "R10 L22 before R13");

    op(1, 13, "R6 start");
    op(0, 22, "R6 second step");
    op(1, 13, "R6 restart on R13 from 10");
    op(0, 22, "R6 second step again");
    op(1, 3, "R6 recovery opens");
    step(0, 1, 0, 0, 0, "R9 relock");

    op(1, 13, "R6 partial");
    op(0, 7, "R6 wrong number L7");
    open_it("R6 recovery after wrong L7");

    step(0, 1, 0, 0, 0, "R9 relock");
    op(1, 13, "R6 partial");
    op(1, 13, "R6 repeat R13 stays 01");
    op(0, 22, "R2 second step");
    step(0, 1, 1, 1, 3, "R9 relock beats final step");
    op(1, 13, "R9 first after relock");
    step(0, 1, 0, 0, 0, "R9 relock from 01");

    open_it("R3 open again");
    step(1, 0, 1, 1, 13, "R1 reset from open");
    open_it("R3 open again");
    step(1, 1, 1, 1, 13, "R1 reset with relock");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule